// File: doc/BRIEF.md
# Twin Phase Detector with Lock Status Output

This block is the digital comparison stage of a two-channel frequency synthesizer. Each channel takes two single-cycle strobes, one from the divided reference and one from the divided feedback, both synchronous to the system clock. Whichever strobe arrives first opens a pump pulse. The pump pulse closes when the other strobe arrives. The pulse is presented as a source or sink command to an external charge pump. Per-channel controls invert the phase polarity, force the pump to high impedance, and gate the channel's power. Power comes either from a software bit alone or from that bit qualified by a hardware pin.

A lock monitor per channel measures every pump pulse in clock cycles. It declares lock once a set number of reference strobes have passed with no pulse wider than a programmed limit. A single status output can show a general-purpose port bit, either lock flag, or the OR of both. In a test setting it can instead show one of the four raw divider strobes. A combinational high/low current select for channel 1 completes the block.

Top module: `twin_pfd_lock`

## Requirements
- R1: With polarity normal (`pol_norm`=1), a reference strobe sampled before the feedback strobe raises `cp_snk` from the next cycle until the edge that samples the feedback strobe. A feedback-first strobe raises `cp_src` in the same way. Strobes sampled together give neither command, and `cp_src` and `cp_snk` are never both high.
- R2: With `pol_norm`=0 the roles of `cp_src` and `cp_snk` are exchanged.
- R3: `pump_tri`=1 on a channel forces its `cp_hiz` high and its `cp_src` and `cp_snk` low.
- R4: A channel is powered when `hw_sel`=0 and `sw_on`=1. It is also powered when `hw_sel`=1, `sw_on`=1 and `hw_pin`=1. In every other combination it is off.
- R5: An unpowered channel drives `cp_hiz` high, shows no lock, and clears its phase state at the next edge, so no stale pump pulse remains when power returns.
- R6: Lock is shown once LOCK_COUNT reference strobes have been sampled on a powered channel since its last clear. It appears in the cycle after the last of those strobes.
- R7: A pump pulse lasting more than WIDTH_LIMIT cycles clears the channel's lock and its strobe count at the edge ending its (WIDTH_LIMIT+1)-th cycle.
- R8: When test mode is not routing, `sts_sel` picks the status output: 2'b00 gives `port_bit`, 2'b01 gives the channel 2 lock, 2'b10 gives the channel 1 lock, and 2'b11 gives the OR of both locks. Channel 1 is index 0 of every vector and channel 2 is index 1.
- R9: With `test_en`=1 and `sts_sel`=2'b10, the status output carries channel 1's reference strobe if `pol_norm[0]`=1, otherwise its feedback strobe. With `test_en`=1 and `sts_sel`=2'b01, it carries channel 2's reference strobe if `pol_norm[1]`=1, otherwise its feedback strobe. The other selections behave as in R8.
- R10: `cp1_hi_cur` is high only when `cur_sw`=1 and either `cur_pin_sel`=0 or `cur_pin`=1.
- R11: While reset is asserted, all pump commands are low, no lock is held, and phase state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_stb | input | 2 | Divided reference strobes, one per channel |
| fb_stb | input | 2 | Divided feedback strobes, one per channel |
| pol_norm | input | 2 | 1 = normal phase polarity, 0 = inverted |
| pump_tri | input | 2 | 1 = force pump to high impedance |
| sw_on | input | 2 | Software power bit, 1 = on |
| hw_sel | input | 2 | 1 = hardware pin also gates power |
| hw_pin | input | 2 | Hardware power pin level, high = on |
| cur_sw | input | 1 | Channel 1 high-current software bit |
| cur_pin_sel | input | 1 | 1 = current-control pin also required |
| cur_pin | input | 1 | Current-control pin level |
| port_bit | input | 1 | General-purpose bit for the status output |
| test_en | input | 1 | Divider test routing enable |
| sts_sel | input | 2 | Status output select |
| cp_src | output | 2 | Source current command per channel |
| cp_snk | output | 2 | Sink current command per channel |
| cp_hiz | output | 2 | Pump high-impedance command per channel |
| cp1_hi_cur | output | 1 | Channel 1 high pump current |
| sts_out | output | 1 | Multiplexed status output |

## Verification
The bench builds the block with WIDTH_LIMIT=3 and LOCK_COUNT=5. With these values a lock is acquired within five reference periods. Feedback offsets of four or five cycles already exceed the width limit, so in the randomized phase lock is gained, lost and regained many times across a few thousand cycles. Power, polarity, tri-state, hardware gating, test routing and all status selections are changed during live pulse traffic. This covers the interaction between a pulse that is in flight and a control change.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    STS_PORT     = 2'b00,
    STS_LOCK_CH2 = 2'b01,
    STS_LOCK_CH1 = 2'b10,
    STS_LOCK_ANY = 2'b11
  } sts_sel_e;

  typedef struct packed {
    logic src;
    logic snk;
    logic hiz;
  } pump_cmd_t;

endpackage

// File: rtl/pfd_channel.sv
module pfd_channel
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_stb,
  input  logic      fb_stb,
  input  logic      pwr_on,
  input  logic      pol_norm,
  input  logic      pump_tri,
  output logic      active,
  output pump_cmd_t cmd
);

  logic ref_lead_q, fb_lead_q;
  logic ref_lead_d, fb_lead_d;
  logic ref_seen, fb_seen;
  logic lead_en;

  always_comb begin
    ref_seen = ref_lead_q | ref_stb;
    fb_seen  = fb_lead_q  | fb_stb;
    lead_en  = ref_stb | fb_stb | ~pwr_on;
    if (!pwr_on) begin
      ref_lead_d = 1'b0;
      fb_lead_d  = 1'b0;
    end else if (ref_seen && fb_seen) begin
      ref_lead_d = 1'b0;
      fb_lead_d  = 1'b0;
    end else begin
      ref_lead_d = ref_seen;
      fb_lead_d  = fb_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lead_q <= 1'b0;
      fb_lead_q  <= 1'b0;
    end else if (lead_en) begin
      ref_lead_q <= ref_lead_d;
      fb_lead_q  <= fb_lead_d;
    end
  end

  always_comb begin
    active  = ref_lead_q | fb_lead_q;
    cmd.hiz = pump_tri | ~pwr_on;
    cmd.snk = ~cmd.hiz & (pol_norm ? ref_lead_q : fb_lead_q);
    cmd.src = ~cmd.hiz & (pol_norm ? fb_lead_q : ref_lead_q);
  end

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int unsigned WIDTH_LIMIT = 4,
  parameter int unsigned LOCK_COUNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic active,
  input  logic ref_stb,
  output logic locked
);

  localparam int unsigned WW = $clog2(WIDTH_LIMIT + 1);
  localparam int unsigned GW = $clog2(LOCK_COUNT + 1);
  localparam logic [WW-1:0] W_MAX = WW'(WIDTH_LIMIT);
  localparam logic [GW-1:0] G_MAX = GW'(LOCK_COUNT);

  logic [WW-1:0] wid_q, wid_d;
  logic [GW-1:0] good_q, good_d;
  logic          too_wide;
  logic          wid_en, good_en;

  always_comb begin
    too_wide = active && (wid_q == W_MAX);
    wid_en   = active || (wid_q != '0);
    if (!active)             wid_d = '0;
    else if (wid_q == W_MAX) wid_d = wid_q;
    else                     wid_d = wid_q + 1'b1;
  end

  always_comb begin
    good_en = 1'b1;
    if (!pwr_on || too_wide)               good_d = '0;
    else if (ref_stb && (good_q != G_MAX)) good_d = good_q + 1'b1;
    else begin
      good_d  = good_q;
      good_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wid_q <= '0;
    else if (wid_en) wid_q <= wid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       good_q <= '0;
    else if (good_en) good_q <= good_d;
  end

  assign locked = pwr_on && (good_q == G_MAX);

endmodule

// File: rtl/status_select.sv
module status_select
  import pfd_pkg::*;
(
  input  logic              test_en,
  input  logic [1:0]        sel,
  input  logic              port_bit,
  input  logic [NUM_CH-1:0] locked,
  input  logic [NUM_CH-1:0] pol_norm,
  input  logic [NUM_CH-1:0] ref_stb,
  input  logic [NUM_CH-1:0] fb_stb,
  output logic              sts_out
);

  sts_sel_e sel_e;

  always_comb begin
    sel_e = sts_sel_e'(sel);
    if (test_en && sel_e == STS_LOCK_CH1) begin
      sts_out = pol_norm[0] ? ref_stb[0] : fb_stb[0];
    end else if (test_en && sel_e == STS_LOCK_CH2) begin
      sts_out = pol_norm[1] ? ref_stb[1] : fb_stb[1];
    end else begin
      unique case (sel_e)
        STS_PORT:     sts_out = port_bit;
        STS_LOCK_CH2: sts_out = locked[1];
        STS_LOCK_CH1: sts_out = locked[0];
        default:      sts_out = |locked;
      endcase
    end
  end

endmodule

// File: rtl/twin_pfd_lock.sv
module twin_pfd_lock
  import pfd_pkg::*;
#(
  parameter int unsigned WIDTH_LIMIT = 4,
  parameter int unsigned LOCK_COUNT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_stb,
  input  logic [1:0] fb_stb,
  input  logic [1:0] pol_norm,
  input  logic [1:0] pump_tri,
  input  logic [1:0] sw_on,
  input  logic [1:0] hw_sel,
  input  logic [1:0] hw_pin,
  input  logic       cur_sw,
  input  logic       cur_pin_sel,
  input  logic       cur_pin,
  input  logic       port_bit,
  input  logic       test_en,
  input  logic [1:0] sts_sel,
  output logic [1:0] cp_src,
  output logic [1:0] cp_snk,
  output logic [1:0] cp_hiz,
  output logic       cp1_hi_cur,
  output logic       sts_out
);

  logic [NUM_CH-1:0] pwr_on;
  logic [NUM_CH-1:0] ch_active;
  logic [NUM_CH-1:0] locked;
  pump_cmd_t         cmd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pwr_on[c] = sw_on[c] & (~hw_sel[c] | hw_pin[c]);

    pfd_channel u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_stb  (ref_stb[c]),
      .fb_stb   (fb_stb[c]),
      .pwr_on   (pwr_on[c]),
      .pol_norm (pol_norm[c]),
      .pump_tri (pump_tri[c]),
      .active   (ch_active[c]),
      .cmd      (cmd[c])
    );

    lock_monitor #(
      .WIDTH_LIMIT (WIDTH_LIMIT),
      .LOCK_COUNT  (LOCK_COUNT)
    ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_on  (pwr_on[c]),
      .active  (ch_active[c]),
      .ref_stb (ref_stb[c]),
      .locked  (locked[c])
    );

    assign cp_src[c] = cmd[c].src;
    assign cp_snk[c] = cmd[c].snk;
    assign cp_hiz[c] = cmd[c].hiz;
  end

  assign cp1_hi_cur = cur_sw & (~cur_pin_sel | cur_pin);

  status_select u_sts (
    .test_en  (test_en),
    .sel      (sts_sel),
    .port_bit (port_bit),
    .locked   (locked),
    .pol_norm (pol_norm),
    .ref_stb  (ref_stb),
    .fb_stb   (fb_stb),
    .sts_out  (sts_out)
  );

endmodule

// File: rtl/twin_pfd_lock_chk.sv
module twin_pfd_lock_chk #(
  parameter int unsigned WIDTH_LIMIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ref_stb,
  input logic [1:0] pump_tri,
  input logic [1:0] hw_sel,
  input logic [1:0] hw_pin,
  input logic [1:0] cp_src,
  input logic [1:0] cp_snk,
  input logic [1:0] cp_hiz,
  input logic [1:0] pwr_on,
  input logic [1:0] ch_active,
  input logic [1:0] locked
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_q <= 0;
      else if (!ch_active[c])       run_q <= 0;
      else if (run_q < WIDTH_LIMIT) run_q <= run_q + 1;
    end

    // R1
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_src[c] && cp_snk[c]));

    // R3
    tri_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pump_tri[c] |-> (cp_hiz[c] && !cp_src[c] && !cp_snk[c]));

    // R4
    hw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_sel[c] && !hw_pin[c]) |-> (cp_hiz[c] && !locked[c]));

    // R5
    pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on[c] |=> (!cp_src[c] && !cp_snk[c]));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(locked[c]) && $past(pwr_on[c])) |-> $past(ref_stb[c]));

    // R7
    wide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active[c] && run_q >= WIDTH_LIMIT) |=> !locked[c]);
  end

endmodule

bind twin_pfd_lock twin_pfd_lock_chk #(.WIDTH_LIMIT(WIDTH_LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_stb   (ref_stb),
  .pump_tri  (pump_tri),
  .hw_sel    (hw_sel),
  .hw_pin    (hw_pin),
  .cp_src    (cp_src),
  .cp_snk    (cp_snk),
  .cp_hiz    (cp_hiz),
  .pwr_on    (pwr_on),
  .ch_active (ch_active),
  .locked    (locked)
);

// File: tb/tb_twin_pfd_lock.sv
`timescale 1ns/100ps
module tb_twin_pfd_lock;

  localparam int WL = 3;
  localparam int LC = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ref_stb, fb_stb, pol_norm, pump_tri, sw_on, hw_sel, hw_pin, sts_sel;
  logic       cur_sw, cur_pin_sel, cur_pin, port_bit, test_en;
  logic [1:0] cp_src, cp_snk, cp_hiz;
  logic       cp1_hi_cur, sts_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  twin_pfd_lock #(.WIDTH_LIMIT(WL), .LOCK_COUNT(LC)) dut (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .pol_norm(pol_norm), .pump_tri(pump_tri), .sw_on(sw_on), .hw_sel(hw_sel),
    .hw_pin(hw_pin), .cur_sw(cur_sw), .cur_pin_sel(cur_pin_sel), .cur_pin(cur_pin),
    .port_bit(port_bit), .test_en(test_en), .sts_sel(sts_sel),
    .cp_src(cp_src), .cp_snk(cp_snk), .cp_hiz(cp_hiz),
    .cp1_hi_cur(cp1_hi_cur), .sts_out(sts_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: per-channel lead flags, pulse age and strobe tally.
  bit m_rl [2];
  bit m_fl [2];
  int m_w  [2];
  int m_g  [2];
  bit m_act, m_wide, m_p;

  function automatic bit m_pwr(int c);
    if (hw_sel[c]) return sw_on[c] && hw_pin[c];
    return bit'(sw_on[c]);
  endfunction

  function automatic bit m_lock(int c);
    return m_pwr(c) && (m_g[c] == LC);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        m_rl[c] = 0; m_fl[c] = 0; m_w[c] = 0; m_g[c] = 0;
      end else begin
        m_act  = m_rl[c] || m_fl[c];
        m_wide = m_act && (m_w[c] == WL);
        m_p    = m_pwr(c);
        if (!m_p || m_wide)            m_g[c] = 0;
        else if (ref_stb[c] && m_g[c] < LC) m_g[c] = m_g[c] + 1;
        if (!m_act)         m_w[c] = 0;
        else if (m_w[c] < WL) m_w[c] = m_w[c] + 1;
        if (!m_p) begin
          m_rl[c] = 0; m_fl[c] = 0;
        end else if ((m_rl[c] || ref_stb[c]) && (m_fl[c] || fb_stb[c])) begin
          m_rl[c] = 0; m_fl[c] = 0;
        end else begin
          m_rl[c] = m_rl[c] || ref_stb[c];
          m_fl[c] = m_fl[c] || fb_stb[c];
        end
      end
    end
  end

  function automatic bit exp_sts();
    if (test_en && sts_sel == 2'b10) return pol_norm[0] ? ref_stb[0] : fb_stb[0];
    if (test_en && sts_sel == 2'b01) return pol_norm[1] ? ref_stb[1] : fb_stb[1];
    case (sts_sel)
      2'b00:   return port_bit;
      2'b01:   return m_lock(1);
      2'b10:   return m_lock(0);
      default: return m_lock(0) || m_lock(1);
    endcase
  endfunction

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      bit eh, es, ek;
      eh = pump_tri[c] || !m_pwr(c);
      es = !eh && (pol_norm[c] ? m_fl[c] : m_rl[c]);
      ek = !eh && (pol_norm[c] ? m_rl[c] : m_fl[c]);
      chk(cp_hiz[c] == eh, "R3 R4 R5 cp_hiz", cp_hiz[c], eh);
      chk(cp_src[c] == es, "R1 R2 R11 cp_src", cp_src[c], es);
      chk(cp_snk[c] == ek, "R1 R2 R11 cp_snk", cp_snk[c], ek);
    end
    chk(sts_out == exp_sts(), "R6 R7 R8 R9 sts_out", sts_out, exp_sts());
    chk(cp1_hi_cur == (cur_sw && (!cur_pin_sel || cur_pin)), "R10 cp1_hi_cur",
        cp1_hi_cur, cur_sw && (!cur_pin_sel || cur_pin));
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    summary();
  end

  int gap [2];
  int off [2];
  bit fbfirst [2];

  initial begin
    rst_n = 1'b0;
    ref_stb = '0; fb_stb = '0; pol_norm = 2'b11; pump_tri = '0;
    sw_on = '0; hw_sel = '0; hw_pin = '0; sts_sel = 2'b00;
    cur_sw = 0; cur_pin_sel = 0; cur_pin = 0; port_bit = 0; test_en = 0;
    step(3);
    // R11 reset state
    chk(cp_src == 2'b00 && cp_snk == 2'b00, "R11 reset pumps", {cp_src, cp_snk}, 0);
    chk(cp_hiz == 2'b11, "R11 reset hiz", cp_hiz, 3);
    rst_n = 1'b1;
    sw_on = 2'b11;
    sts_sel = 2'b10;
    step(2);

    // R6 lock acquisition on channel 1 with narrow pulses
    for (int n = 0; n < LC; n++) begin
      if (n == LC - 1) chk(sts_out == 1'b0, "R6 not yet locked", sts_out, 0);
      ref_stb[0] = 1; step(); ref_stb[0] = 0;
      if (n == 0) chk(cp_snk[0] == 1'b1, "R1 ref first sinks", cp_snk[0], 1);
      step(); fb_stb[0] = 1; step(); fb_stb[0] = 0;
      if (n == 0) chk(cp_snk[0] == 1'b0, "R1 sink ends on feedback", cp_snk[0], 0);
      step(2);
    end
    chk(sts_out == 1'b1, "R6 locked after count", sts_out, 1);
    sts_sel = 2'b11; #1;
    chk(sts_out == 1'b1, "R8 wired OR of locks", sts_out, 1);
    sts_sel = 2'b01; #1;
    chk(sts_out == 1'b0, "R8 channel 2 lock", sts_out, 0);
    sts_sel = 2'b00; port_bit = 1; #1;
    chk(sts_out == 1'b1, "R8 port bit", sts_out, 1);
    sts_sel = 2'b10;

    // R1 feedback first sources; R2 inverted swaps
    fb_stb[0] = 1; step(); fb_stb[0] = 0;
    chk(cp_src[0] == 1'b1, "R1 feedback first sources", cp_src[0], 1);
    ref_stb[0] = 1; step(); ref_stb[0] = 0;
    pol_norm[0] = 0;
    ref_stb[0] = 1; step(); ref_stb[0] = 0;
    chk(cp_src[0] == 1'b1 && cp_snk[0] == 1'b0, "R2 inverted ref first sources",
        {cp_src[0], cp_snk[0]}, 2);
    // R7 overlong pulse drops lock
    step(WL + 1);
    chk(sts_out == 1'b0, "R7 lock lost on wide pulse", sts_out, 0);
    fb_stb[0] = 1; step(); fb_stb[0] = 0;
    pol_norm[0] = 1;

    // R3 tri-state during a pulse
    ref_stb[1] = 1; step(); ref_stb[1] = 0;
    pump_tri[1] = 1; #1;
    chk(cp_hiz[1] == 1'b1 && cp_snk[1] == 1'b0, "R3 tri forces hiz",
        {cp_hiz[1], cp_snk[1]}, 2);
    pump_tri[1] = 0; fb_stb[1] = 1; step(); fb_stb[1] = 0;

    // R4 hardware power selection, R5 clears phase
    hw_sel[1] = 1; hw_pin[1] = 0;
    ref_stb[1] = 1; step(); ref_stb[1] = 0;
    chk(cp_hiz[1] == 1'b1, "R4 pin low powers off", cp_hiz[1], 1);
    hw_pin[1] = 1; #1;
    chk(cp_hiz[1] == 1'b0 && cp_snk[1] == 1'b0, "R5 no stale pulse after power",
        {cp_hiz[1], cp_snk[1]}, 0);
    sw_on[1] = 0; #1;
    chk(cp_hiz[1] == 1'b1, "R4 software bit still required", cp_hiz[1], 1);
    sw_on[1] = 1; hw_sel[1] = 0; step();

    // R9 test routing
    test_en = 1; sts_sel = 2'b10; pol_norm[0] = 1; ref_stb[0] = 1; #1;
    chk(sts_out == 1'b1, "R9 channel 1 reference routed", sts_out, 1);
    pol_norm[0] = 0; #1;
    chk(sts_out == 1'b0, "R9 channel 1 feedback routed", sts_out, 0);
    step(); ref_stb[0] = 0; pol_norm[0] = 1;
    sts_sel = 2'b01; pol_norm[1] = 0; fb_stb[1] = 1; #1;
    chk(sts_out == 1'b1, "R9 channel 2 feedback routed", sts_out, 1);
    step(); fb_stb[1] = 0; pol_norm[1] = 1; test_en = 0; step();
    fb_stb[0] = 1; fb_stb[1] = 1; step(); fb_stb = '0; step();

    // R10 current select
    cur_sw = 1; cur_pin_sel = 1; cur_pin = 0; #1;
    chk(cp1_hi_cur == 1'b0, "R10 pin low blocks high current", cp1_hi_cur, 0);
    cur_pin = 1; #1;
    chk(cp1_hi_cur == 1'b1, "R10 pin high enables", cp1_hi_cur, 1);
    cur_sw = 0; #1;
    chk(cp1_hi_cur == 1'b0, "R10 software bit required", cp1_hi_cur, 0);
    step();

    // Randomized pulse traffic with periodic control changes
    gap[0] = 0; gap[1] = 4;
    for (int t = 0; t < 6000; t++) begin
      if (t % 64 == 0) begin
        pol_norm = 2'($urandom);
        pump_tri = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
        sw_on    = (($urandom % 6) == 0) ? 2'($urandom) : 2'b11;
        hw_sel   = 2'($urandom);
        hw_pin   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
        sts_sel  = 2'($urandom);
        test_en  = (($urandom % 4) == 0);
        port_bit = 1'($urandom);
        cur_sw = 1'($urandom); cur_pin_sel = 1'($urandom); cur_pin = 1'($urandom);
      end
      for (int c = 0; c < 2; c++) begin
        ref_stb[c] = 0; fb_stb[c] = 0;
        if (gap[c] == 0) begin
          off[c] = $urandom % 8;
          if (off[c] > 5) off[c] = 1;
          fbfirst[c] = (($urandom % 4) == 0);
        end
        if (gap[c] == 0)      begin if (fbfirst[c]) fb_stb[c] = 1; else ref_stb[c] = 1; end
        if (gap[c] == off[c]) begin if (fbfirst[c]) ref_stb[c] = 1; else fb_stb[c] = 1; end
        gap[c] = (gap[c] + 1) % 10;
      end
      step();
    end
    ref_stb = '0; fb_stb = '0;
    step(3);
    summary();
  end

endmodule